// File: doc/BRIEF.md
# Sequential Combination Lock

This block is a clocked Moore state machine that models a dial lock. Each dial operation is offered as a direction bit and a 5-bit dial number, qualified by a single-cycle valid strobe. The lock opens only after it sees three operations in one fixed order: right 13, then left 22, then right 3. Any other order of the same values leaves it shut.

The machine keeps a 2-bit state. The `unlocked` output is decoded from that state alone, so no input can reach the output inside a cycle. Once open, the lock stays open until a relock request or a synchronous active-low reset sends it back to idle. The expected steps are parameters, but the three-step order is built into the design.

Top module: `combo_lock`

## Requirements
- R1: A cycle in which `rst_n` is low at the rising clock edge puts the lock in idle: `lock_state` reads 2'b00 and `unlocked` reads 0 after that edge.
- R2: The state encoding is idle=2'b00, first-step-done=2'b01, second-step-done=2'b10, open=2'b11. `unlocked` is 1 exactly when `lock_state` is 2'b11, and it changes only together with the state.
- R3: In a cycle where `op_valid` and `relock` are both low, the state does not change.
- R4: From idle, a valid operation with `op_dir`=1 (right) and `op_num`=13 moves the lock to 2'b01.
- R5: From 2'b01, a valid operation with `op_dir`=0 (left) and `op_num`=22 moves the lock to 2'b10.
- R6: From 2'b10, a valid right 3 moves the lock to 2'b11, and `unlocked` rises on that same edge.
- R7: In states 2'b00, 2'b01 or 2'b10, a valid operation that is not the expected next step returns the lock to 2'b00. A valid right 13 is the exception: it always lands the lock in 2'b01.
- R8: In the open state, valid operations have no effect, and the lock stays at 2'b11.
- R9: `relock` high at a clock edge sends the lock to 2'b00 from any state and overrides a valid operation offered in the same cycle.
- R10: The three correct values offered in any other order do not open the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | High for one cycle when a dial operation is offered |
| op_dir | input | 1 | Dial direction: 1 = right, 0 = left |
| op_num | input | 5 | Dial number, 0 to 31 |
| relock | input | 1 | Closes the lock and returns it to idle |
| lock_state | output | 2 | Current state code |
| unlocked | output | 1 | High while the lock is open |

## Verification
The assertions check on every cycle that the state holds without a strobe, that relock always lands in idle, that the open state holds without relock, that the first right-13 step advances from idle, and that `unlocked` can only rise out of the second-step state following a strobed right 3. Other behaviour can only be shown by the bench's ordered scenarios. These are whole sequences such as permuted combinations, a restart in the middle of a sequence on right 13, a wrong direction with the right number, and a reset taken from the open state.

// File: rtl/combo_lock_pkg.sv
// Package: shared state type and constants for the combination lock.
// Assumes a fixed three-step combination, which gives four states.
package combo_lock_pkg;

    localparam int NUM_STEPS = 3;
    localparam int STATE_W   = 2;

    localparam logic DIR_RIGHT = 1'b1;
    localparam logic DIR_LEFT  = 1'b0;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_OPEN = 2'b11
    } lock_state_t;

endpackage

// File: rtl/dial_step_match.sv
// Module: compares the incoming dial operation with every expected step
// of the combination and gives one hit bit per step.
// Assumes the step numbers are packed with step 0 in the low bits.
module dial_step_match #(
    parameter int                         DIAL_W    = 5,
    parameter int                         NUM_STEPS = 3,
    parameter logic [NUM_STEPS-1:0]       STEP_DIRS = '0,
    parameter logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS = '0
) (
    input  logic                 op_dir,
    input  logic [DIAL_W-1:0]    op_num,
    output logic [NUM_STEPS-1:0] hit
);

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_step
        localparam logic [DIAL_W-1:0] EXP_NUM = STEP_NUMS[g*DIAL_W +: DIAL_W];
        localparam logic              EXP_DIR = STEP_DIRS[g];
        // Exact match on both direction and number for step g.
        always_comb begin
            hit[g] = (op_dir == EXP_DIR) && (op_num == EXP_NUM);
        end
    end

endmodule

// File: rtl/lock_next_state.sv
// Module: next-state logic of the lock.
// Assumes hit[0..2] flag the first, second and third steps. Relock has the
// highest priority, and the state holds when no operation is strobed.
module lock_next_state
    import combo_lock_pkg::*;
(
    input  lock_state_t          cur,
    input  logic                 op_valid,
    input  logic                 relock,
    input  logic [NUM_STEPS-1:0] hit,
    output lock_state_t          nxt
);

    // Picks the following state from the current state and the step hits.
    always_comb begin
        nxt = cur;
        if (relock) begin
            nxt = ST_IDLE;
        end else if (op_valid) begin
            unique case (cur)
                ST_IDLE: nxt = hit[0] ? ST_ONE : ST_IDLE;
                ST_ONE:  nxt = hit[1] ? ST_TWO : (hit[0] ? ST_ONE : ST_IDLE);
                ST_TWO:  nxt = hit[2] ? ST_OPEN : (hit[0] ? ST_ONE : ST_IDLE);
                ST_OPEN: nxt = ST_OPEN;
                default: nxt = ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lock_state_reg.sv
// Module: the two state flip-flops, with a synchronous active-low reset.
// Assumes reset is sampled on the rising clock edge only.
module lock_state_reg
    import combo_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  lock_state_t nxt,
    output lock_state_t cur
);

    // Loads the next state, or idle while reset is low.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= ST_IDLE;
        else        cur <= nxt;
    end

endmodule

// File: rtl/combo_lock.sv
// Module: top of the sequential combination lock (Moore machine).
// Assumes op_valid is high for one cycle per dial operation and that
// op_dir = 1 means right. unlocked is decoded from the state register only.
module combo_lock
    import combo_lock_pkg::*;
#(
    parameter int   DIAL_W    = 5,
    parameter int   STEP0_NUM = 13,
    parameter logic STEP0_DIR = DIR_RIGHT,
    parameter int   STEP1_NUM = 22,
    parameter logic STEP1_DIR = DIR_LEFT,
    parameter int   STEP2_NUM = 3,
    parameter logic STEP2_DIR = DIR_RIGHT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_dir,
    input  logic [DIAL_W-1:0] op_num,
    input  logic              relock,
    output logic [1:0]        lock_state,
    output logic              unlocked
);

    localparam logic [DIAL_W-1:0] S0_NUM = DIAL_W'(STEP0_NUM);
    localparam logic [DIAL_W-1:0] S1_NUM = DIAL_W'(STEP1_NUM);
    localparam logic [DIAL_W-1:0] S2_NUM = DIAL_W'(STEP2_NUM);
    localparam logic [NUM_STEPS*DIAL_W-1:0] STEP_NUMS = {S2_NUM, S1_NUM, S0_NUM};
    localparam logic [NUM_STEPS-1:0]        STEP_DIRS = {STEP2_DIR, STEP1_DIR, STEP0_DIR};

    logic [NUM_STEPS-1:0] hit;
    lock_state_t          cur;
    lock_state_t          nxt;

    dial_step_match #(
        .DIAL_W    (DIAL_W),
        .NUM_STEPS (NUM_STEPS),
        .STEP_DIRS (STEP_DIRS),
        .STEP_NUMS (STEP_NUMS)
    ) u_match (
        .op_dir (op_dir),
        .op_num (op_num),
        .hit    (hit)
    );

    lock_next_state u_next (
        .cur      (cur),
        .op_valid (op_valid),
        .relock   (relock),
        .hit      (hit),
        .nxt      (nxt)
    );

    lock_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt),
        .cur   (cur)
    );

    // Moore output decode: depends on the registered state only.
    always_comb begin
        lock_state = cur;
        unlocked   = (cur == ST_OPEN);
    end

    // R3: with no strobe and no relock, the state register keeps its value.
    assert_hold_idle_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !relock) |=> $stable(lock_state));

    // R4: the first step of the combination advances the lock out of idle.
    assert_first_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == 2'b00 && op_valid && !relock && op_dir == STEP0_DIR && op_num == S0_NUM)
        |=> lock_state == 2'b01);

    // R6: unlocked rises only from the second-step state after a strobed final step.
    assert_open_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(lock_state) == 2'b10 && $past(op_valid) &&
                             $past(op_dir) == STEP2_DIR && $past(op_num) == S2_NUM));

    // R8: the open state holds while relock stays low.
    assert_open_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && !relock) |=> unlocked);

    // R9: relock always returns the lock to idle.
    assert_relock_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        relock |=> (lock_state == 2'b00 && !unlocked));

endmodule

// File: tb/sim_combo_lock.sv
`timescale 1ns/1ps
module sim_combo_lock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [4:0] op_num = '0;
    logic       relock = 1'b0;
    logic [1:0] lock_state;
    logic       unlocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic R = 1'b1;
    localparam logic L = 1'b0;

    always #2.5 clk = ~clk;

    combo_lock u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_dir     (op_dir),
        .op_num     (op_num),
        .relock     (relock),
        .lock_state (lock_state),
        .unlocked   (unlocked)
    );

    // Compares the state and the open flag against the expected values.
    task automatic expect_state(input string req, input logic [1:0] st);
        checks++;
        if (lock_state !== st || unlocked !== (st == 2'b11)) begin
            errors++;
            $display("FAIL %s: state=%b unlocked=%b expected state=%b unlocked=%b",
                     req, lock_state, unlocked, st, (st == 2'b11));
        end
    endtask

    // Offers one strobed operation; returns at the next falling edge.
    task automatic dial(input logic d, input logic [4:0] n);
        @(negedge clk);
        op_valid = 1'b1; op_dir = d; op_num = n;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Holds reset low for two edges.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        expect_state("R1 reset", 2'b00);
    endtask

    task automatic t_open_sequence();
        do_reset();
        dial(R, 5'd13); expect_state("R4 right13", 2'b01);
        dial(L, 5'd22); expect_state("R5 left22", 2'b10);
        dial(R, 5'd3);  expect_state("R6 right3 opens", 2'b11);
        expect_state("R2 encoding open", 2'b11);
    endtask

    task automatic t_hold();
        do_reset();
        dial(R, 5'd13);
        repeat (5) @(negedge clk);
        expect_state("R3 hold without strobe", 2'b01);
        dial(L, 5'd22);
        repeat (3) @(negedge clk);
        expect_state("R3 hold in second step", 2'b10);
    endtask

    task automatic t_wrong_ops();
        do_reset();
        dial(R, 5'd13); dial(R, 5'd22);
        expect_state("R7 wrong dir in step1", 2'b00);
        dial(R, 5'd13); dial(L, 5'd22); dial(L, 5'd3);
        expect_state("R7 wrong dir in step2", 2'b00);
        dial(L, 5'd13);
        expect_state("R7 left13 from idle", 2'b00);
        dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd4);
        expect_state("R7 wrong number in step2", 2'b00);
    endtask

    task automatic t_restart();
        do_reset();
        dial(R, 5'd13); dial(R, 5'd13);
        expect_state("R7 right13 in step1 stays", 2'b01);
        dial(L, 5'd22); dial(R, 5'd13);
        expect_state("R7 right13 in step2 restarts", 2'b01);
        dial(L, 5'd22); dial(R, 5'd3);
        expect_state("R7 open after restart", 2'b11);
    endtask

    task automatic t_out_of_order();
        do_reset();
        dial(L, 5'd22); dial(R, 5'd13); dial(R, 5'd3);
        expect_state("R10 order L22 R13 R3", 2'b00);
        do_reset();
        dial(R, 5'd3); dial(R, 5'd13); dial(L, 5'd22);
        expect_state("R10 order R3 R13 L22", 2'b10);
        do_reset();
        dial(R, 5'd13); dial(R, 5'd3); dial(L, 5'd22);
        expect_state("R10 order R13 R3 L22", 2'b00);
    endtask

    task automatic t_open_ignores();
        do_reset();
        dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd3);
        dial(R, 5'd13);
        expect_state("R8 open ignores right13", 2'b11);
        dial(L, 5'd7);
        expect_state("R8 open ignores left7", 2'b11);
    endtask

    task automatic t_relock();
        do_reset();
        dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd3);
        @(negedge clk); relock = 1'b1;
        @(negedge clk); relock = 1'b0;
        expect_state("R9 relock from open", 2'b00);
        dial(R, 5'd13);
        @(negedge clk); relock = 1'b1; op_valid = 1'b1; op_dir = L; op_num = 5'd22;
        @(negedge clk); relock = 1'b0; op_valid = 1'b0;
        expect_state("R9 relock overrides step", 2'b00);
        @(negedge clk); relock = 1'b1; op_valid = 1'b1; op_dir = R; op_num = 5'd13;
        @(negedge clk); relock = 1'b0; op_valid = 1'b0;
        expect_state("R9 relock overrides right13 in idle", 2'b00);
    endtask

    task automatic t_reset_from_open();
        do_reset();
        dial(R, 5'd13); dial(L, 5'd22); dial(R, 5'd3);
        do_reset();
        expect_state("R1 reset from open", 2'b00);
    endtask

    initial begin
        t_reset();
        t_open_sequence();
        t_hold();
        t_wrong_ops();
        t_restart();
        t_out_of_order();
        t_open_ignores();
        t_relock();
        t_reset_from_open();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule